// File: doc/BRIEF.md
# Configurable I/O Port with Capture/Compare Latch Sharing

This block is a 16-line general-purpose I/O port. Each line has a bit in a data latch, a bit in a direction register and a bit in a drive-mode register. Software reaches all three over a small word-addressed register bus. Each pad is modelled as three signals: an output value, an output enable and an input value. Input values pass through a two-flop synchroniser before they are used anywhere.

The same lines also serve a capture/compare unit. For each line, that unit can update the output latch when it pulses a compare trigger. Two update rules exist:

- toggle: the latch is inverted.
- set/clear: a match sets the latch and a timer overflow clears it.

The port sends one capture data bit per line back to the unit. For an input line this bit is the synchronised pin. For an output line it is the output latch, so a software write to the latch can trigger a capture.

Top module: `pinbank_ccio`

## Requirements
- R1: After reset the latch, direction and drive-mode registers are all zero. Every line is then an input, `pad_oe` is 0000h, `pad_out` is 0000h and `bus_rdata` is 0000h.
- R2: The bus writes the direction register at byte address 2 and the drive-mode register at byte address 4. Each write takes effect at the clock edge where `bus_we` is high. Both registers read back what was written. At addresses other than 0, 2 and 4, writes are ignored and reads return 0000h.
- R3: A line in push/pull mode (drive-mode bit 0) has `pad_oe` equal to its direction bit and `pad_out` equal to its latch bit.
- R4: A line in open-drain mode (drive-mode bit 1) has `pad_out` at 0. Its `pad_oe` is 1 only when the direction bit is 1 and the latch bit is 0.
- R5: A change on `pad_in` reaches the synchronised pin state at the second rising edge after it is applied, and not earlier.
- R6: `cc_capdata` of a line equals its latch bit when the direction bit is 1. It equals the synchronised pin state when the direction bit is 0.
- R7: A line with `cc_trig` high and `cc_setclr` low inverts its latch at that edge.
- R8: A line with `cc_trig` high and `cc_setclr` high sets its latch when `cc_ovf` is 0 and clears it when `cc_ovf` is 1.
- R9: A bus write of the data register (byte address 0) loads the latch bit of every line whose `cc_trig` is low. Lines with `cc_trig` high in the same cycle follow R7/R8 and ignore the written bit.
- R10: `bus_rdata` is registered. In the cycle after `bus_re` it holds the addressed value and is 0000h in any cycle that follows no read. A data read returns, per line, the latch bit for outputs and the synchronised pin for inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte address: 0 data, 2 direction, 4 drive mode |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_re` |
| pad_in | input | 16 | Raw pad input values |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad driver enables |
| cc_trig | input | 16 | Per-line compare trigger |
| cc_setclr | input | 16 | Per-line compare rule: 0 toggle, 1 set/clear |
| cc_ovf | input | 16 | Per-line qualifier: 1 overflow (clear), 0 match (set) |
| cc_capdata | output | 16 | Per-line capture data to the capture/compare unit |

## Verification
Latch, direction and drive-mode updates are visible on `pad_out`, `pad_oe` and `cc_capdata` one edge after the write or trigger, because those outputs are combinational from the registers. `bus_rdata` follows one edge after the read strobe and reflects the state from before that edge. A `pad_in` change appears on input lines' `cc_capdata` two edges later. The bench applies stimulus at the falling edge and advances a reference model at the rising edge. It compares all four outputs at the next falling edge, so every result is sampled in the first cycle in which it is due.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int OFS_DATA = 0;
  localparam int OFS_DIR  = 2;
  localparam int OFS_MODE = 4;

  // next latch value produced by a compare trigger
  function automatic logic cmp_next(input logic cur, input logic setclr, input logic ovf);
    if (setclr) return ~ovf;
    return ~cur;
  endfunction

  // pad value for a line given drive mode and latch
  function automatic logic drive_val(input logic od, input logic q);
    return od ? 1'b0 : q;
  endfunction

  // pad enable for a line given direction, drive mode and latch
  function automatic logic drive_en(input logic dir, input logic od, input logic q);
    if (!dir) return 1'b0;
    if (od) return ~q;
    return 1'b1;
  endfunction

  // observed line state: latch for outputs, synchronised pin for inputs
  function automatic logic line_view(input logic dir, input logic q, input logic pin);
    return dir ? q : pin;
  endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= raw_in;
      sync_out <= stage1;
    end
  end

endmodule

// File: rtl/pinbank_line.sv
module pinbank_line
  import pinbank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_bit,
  input  logic trig,
  input  logic setclr,
  input  logic ovf,
  input  logic dir,
  input  logic od,
  input  logic pin_sync,
  output logic q,
  output logic pad_o,
  output logic pad_en,
  output logic cap_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (trig) begin
      q <= cmp_next(q, setclr, ovf);
    end else if (sw_wr) begin
      q <= sw_bit;
    end
  end

  always_comb begin
    pad_o  = drive_val(od, q);
    pad_en = drive_en(dir, od, q);
    cap_o  = line_view(dir, q, pin_sync);
  end

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [W-1:0]  lat_q,
  input  logic [W-1:0]  pin_sync,
  output logic          data_wr,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  od_q,
  output logic [W-1:0]  bus_rdata
);

  logic sel_data, sel_dir, sel_mode;
  logic [W-1:0] view_data;
  logic [W-1:0] rd_mux;

  assign sel_data = (bus_addr == AW'(OFS_DATA));
  assign sel_dir  = (bus_addr == AW'(OFS_DIR));
  assign sel_mode = (bus_addr == AW'(OFS_MODE));
  assign data_wr  = bus_we && sel_data;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      view_data[i] = line_view(dir_q[i], lat_q[i], pin_sync[i]);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_data)      rd_mux = view_data;
    else if (sel_dir)  rd_mux = dir_q;
    else if (sel_mode) rd_mux = od_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      od_q      <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_we && sel_dir)  dir_q <= bus_wdata;
      if (bus_we && sel_mode) od_q  <= bus_wdata;
      bus_rdata <= bus_re ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/pinbank_ccio.sv
module pinbank_ccio #(
  parameter int NLINES = 16,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  input  logic [NLINES-1:0] cc_trig,
  input  logic [NLINES-1:0] cc_setclr,
  input  logic [NLINES-1:0] cc_ovf,
  output logic [NLINES-1:0] cc_capdata
);

  logic [NLINES-1:0] sync_pin;
  logic [NLINES-1:0] lat_q;
  logic [NLINES-1:0] dir_q;
  logic [NLINES-1:0] od_q;
  logic              data_wr;

  pinbank_sync #(.W(NLINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pad_in),
    .sync_out (sync_pin)
  );

  pinbank_regs #(.W(NLINES), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .lat_q     (lat_q),
    .pin_sync  (sync_pin),
    .data_wr   (data_wr),
    .dir_q     (dir_q),
    .od_q      (od_q),
    .bus_rdata (bus_rdata)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    pinbank_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_wr    (data_wr),
      .sw_bit   (bus_wdata[g]),
      .trig     (cc_trig[g]),
      .setclr   (cc_setclr[g]),
      .ovf      (cc_ovf[g]),
      .dir      (dir_q[g]),
      .od       (od_q[g]),
      .pin_sync (sync_pin[g]),
      .q        (lat_q[g]),
      .pad_o    (pad_out[g]),
      .pad_en   (pad_oe[g]),
      .cap_o    (cc_capdata[g])
    );
  end

endmodule

// File: rtl/pinbank_checker.sv
module pinbank_checker #(
  parameter int NLINES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_re,
  input logic [NLINES-1:0] bus_rdata,
  input logic [NLINES-1:0] cc_trig,
  input logic [NLINES-1:0] cc_setclr,
  input logic [NLINES-1:0] cc_ovf,
  input logic [NLINES-1:0] lat_q,
  input logic [NLINES-1:0] dir_q,
  input logic [NLINES-1:0] od_q,
  input logic [NLINES-1:0] sync_pin,
  input logic [NLINES-1:0] pad_out,
  input logic [NLINES-1:0] pad_oe,
  input logic [NLINES-1:0] cc_capdata
);

  logic [NLINES-1:0] tog_mask, set_mask, clr_mask;
  assign tog_mask = cc_trig & ~cc_setclr;
  assign set_mask = cc_trig & cc_setclr & ~cc_ovf;
  assign clr_mask = cc_trig & cc_setclr & cc_ovf;

  assert_no_input_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);

  assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & od_q) == '0) && ((pad_oe & od_q & lat_q) == '0));

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_mask != '0) |=> (((lat_q ^ $past(lat_q)) & $past(tog_mask)) == $past(tog_mask)));

  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((lat_q & $past(set_mask)) == $past(set_mask)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((lat_q & $past(clr_mask)) == '0));

  assert_capture_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cc_capdata ^ sync_pin) & ~dir_q) == '0);

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0));

endmodule

bind pinbank_ccio pinbank_checker #(.NLINES(NLINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_re     (bus_re),
  .bus_rdata  (bus_rdata),
  .cc_trig    (cc_trig),
  .cc_setclr  (cc_setclr),
  .cc_ovf     (cc_ovf),
  .lat_q      (lat_q),
  .dir_q      (dir_q),
  .od_q       (od_q),
  .sync_pin   (sync_pin),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .cc_capdata (cc_capdata)
);

// File: tb/pinbank_ccio_bench.sv
module pinbank_ccio_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic         bus_re = 1'b0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, cc_capdata;
  logic [N-1:0] cc_trig = '0, cc_setclr = '0, cc_ovf = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference state
  logic [N-1:0] m_q = '0, m_dir = '0, m_od = '0, m_s1 = '0, m_s2 = '0, m_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinbank_ccio u_pinbank_ccio (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .cc_trig(cc_trig), .cc_setclr(cc_setclr),
    .cc_ovf(cc_ovf), .cc_capdata(cc_capdata)
  );

  function automatic logic [N-1:0] exp_view(input logic [N-1:0] d, input logic [N-1:0] q,
                                            input logic [N-1:0] p);
    return (d & q) | (~d & p);
  endfunction

  function automatic logic [N-1:0] exp_oe(input logic [N-1:0] d, input logic [N-1:0] o,
                                          input logic [N-1:0] q);
    return d & ~(o & q);
  endfunction

  function automatic logic [N-1:0] exp_q(input logic [N-1:0] q, input logic wr,
                                         input logic [N-1:0] wd, input logic [N-1:0] t,
                                         input logic [N-1:0] sc, input logic [N-1:0] ov);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (t[i])    r[i] = sc[i] ? ~ov[i] : ~q[i];
      else if (wr) r[i] = wd[i];
      else         r[i] = q[i];
    end
    return r;
  endfunction

  task automatic check(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("pad_out",    pad_out,    m_q & ~m_od);
    check("pad_oe",     pad_oe,     exp_oe(m_dir, m_od, m_q));
    check("cc_capdata", cc_capdata, exp_view(m_dir, m_q, m_s2));
    check("bus_rdata",  bus_rdata,  m_rd);
  endtask

  // one clock: model advances on the rising edge, outputs checked at the falling edge
  task automatic step();
    logic [N-1:0] nrd;
    @(posedge clk);
    nrd = '0;
    if (bus_re) begin
      case (bus_addr)
        3'd0: nrd = exp_view(m_dir, m_q, m_s2);
        3'd2: nrd = m_dir;
        3'd4: nrd = m_od;
        default: nrd = '0;
      endcase
    end
    m_q  = exp_q(m_q, bus_we && bus_addr == 3'd0, bus_wdata, cc_trig, cc_setclr, cc_ovf);
    if (bus_we && bus_addr == 3'd2) m_dir = bus_wdata;
    if (bus_we && bus_addr == 3'd4) m_od  = bus_wdata;
    m_s2 = m_s1;
    m_s1 = pad_in;
    m_rd = nrd;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    bus_we = 0; bus_re = 0; cc_trig = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1; bus_re = 0;
    step();
    idle();
  endtask

  task automatic rd(input logic [2:0] a);
    bus_addr = a; bus_re = 1; bus_we = 0;
    step();
    idle();
    step();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    cur_tag = "R1";
    compare_all();
    rst_n = 1;
    step();

    // R2: configuration registers and unused addresses
    cur_tag = "R2";
    wr(3'd2, 16'hFFFF);
    rd(3'd2);
    wr(3'd4, 16'h00FF);
    rd(3'd4);
    wr(3'd6, 16'hBEEF);
    rd(3'd6);
    wr(3'd1, 16'h1234);
    rd(3'd0);

    // R3 and R4: push/pull upper byte, open drain lower byte
    cur_tag = "R3/R4";
    wr(3'd0, 16'hA55A);
    wr(3'd0, 16'h5AA5);

    // R7: toggle on selected lines
    cur_tag = "R7";
    cc_trig = 16'h0F0F; cc_setclr = '0; step(); idle();
    cc_trig = 16'h0F0F; step(); idle();

    // R8: set then clear
    cur_tag = "R8";
    cc_trig = 16'hFFFF; cc_setclr = 16'hFFFF; cc_ovf = 16'hFF00; step(); idle();
    cc_trig = 16'h00FF; cc_ovf = 16'h00FF; step(); idle();

    // R9: software write colliding with compare triggers
    cur_tag = "R9";
    bus_addr = 3'd0; bus_wdata = 16'hFFFF; bus_we = 1;
    cc_trig = 16'h8001; cc_setclr = 16'h0001; cc_ovf = 16'h0001;
    step(); idle();
    rd(3'd0);

    // R5 and R6: inputs through the synchroniser
    cur_tag = "R5";
    wr(3'd2, 16'h0000);
    pad_in = 16'h1234;
    step(); step(); step();
    cur_tag = "R6";
    wr(3'd2, 16'hF0F0);
    pad_in = 16'hFFFF;
    step(); step();
    rd(3'd0);

    // R10: random traffic with reads
    cur_tag = "R10 random";
    for (int k = 0; k < 3000; k++) begin
      bus_addr  = 3'($urandom_range(0, 7));
      bus_wdata = N'($urandom);
      bus_we    = ($urandom_range(0, 3) == 0);
      bus_re    = ($urandom_range(0, 2) == 0);
      pad_in    = ($urandom_range(0, 3) == 0) ? N'($urandom) : pad_in;
      cc_trig   = N'($urandom) & N'($urandom) & N'($urandom);
      cc_setclr = N'($urandom);
      cc_ovf    = N'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule